// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block performs one shift or rotate per accepted request. It supports logical shifts in both directions, an arithmetic right shift, plain rotates in both directions and rotates that pass through the carry flag. The operand may be 1, 2, 4 or 8 bytes wide. The block returns two things: the destination value merged at the operand size, and an updated condition-flag word. A select mask names the flag bits the operation may write. Every other flag bit passes through unchanged.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream, one registered stage later. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or its content is leaving in the same cycle. A result is offered on `out_valid`. While `out_ready` is low, the result holds steady and no new request is taken.

Top module: `shrot_unit`

## Requirements
- R1: A request accepted on a clock edge appears on `out_valid`, `out_dst` and `out_flags` one edge later. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the outputs stay stable. Reset empties the result register.
- R2: The effective count is `in_cnt[5:0]` for 8-byte operands and `in_cnt[4:0]` for the other sizes. Higher count bits have no effect.
- R3: When the effective count is zero, `out_flags` equals `in_flags`. For rotates (op 3..6), `out_dst` equals `in_dst`. For shifts (op 0..2), the source is written, merged as in R12.
- R4: Flag bits are laid out as CF=0, PF=1, ZF=2, SF=3, OF=4 and XCF (extended carry)=5. A bit is written only when the matching bit of `in_sel` is set. Bits 6 and 7, and every unselected bit, copy `in_flags`. CF and XCF both receive the same carry-out.
- R5: Op 0 is a left shift that fills with zeros. Carry is source bit (W-count), or 0 when count > W. Overflow is carry XOR result MSB. W is the operand width in bits.
- R6: Op 1 is a logical right shift that fills with zeros. Carry is source bit (count-1), or 0 beyond the operand. Overflow is the source MSB.
- R7: Op 2 is an arithmetic right shift that fills with the source sign. Carry is source bit (count-1), or the sign bit beyond the operand. Overflow is written 0 when selected.
- R8: Op 3 rotates right by count mod W. Carry is the result MSB and overflow is result MSB XOR result bit W-2. Op 4 rotates left by count mod W. Carry is the result LSB and overflow is result MSB XOR result LSB.
- R9: Op 5 rotates {carry, source} right by count mod (W+1). The old carry enters at bit W-count, and the new carry is source bit count-1. Overflow is old carry XOR source MSB.
- R10: Op 6 rotates {carry, source} left by count mod (W+1). The old carry enters at bit count-1, and the new carry is source bit W-count. Overflow is result MSB XOR new carry.
- R11: ZF is set when the W-bit result is zero. SF is the result MSB. PF is set when the low result byte holds an even number of ones. Each of these is written only when selected and the count is non-zero.
- R12: Sizes are encoded 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. Sizes 0 and 1 keep the `in_dst` bits above the operand. Size 2 zeroes bits 63:32.
- R13: Op 7 is reserved. It returns `in_dst` and `in_flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Operand size code |
| in_src | input | 64 | Source operand |
| in_dst | input | 64 | Previous destination value |
| in_cnt | input | 8 | Shift or rotate count |
| in_flags | input | 8 | Current flag word |
| in_sel | input | 8 | Flag write select |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_dst | output | 64 | Merged destination |
| out_flags | output | 8 | Updated flag word |

## Verification
The bench builds the unit with its default parameters: four operand sizes up to 64 bits and an 8-bit count input. This setup makes count masking reachable at both 5 and 6 bits. It also exercises counts above the operand width for the byte and halfword lanes. For the through-carry rotates it covers the full-period wrap at 9 and 17 positions. Random back-pressure on `out_ready` exercises the stall path.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROR = 3'd3,
    OP_ROL = 3'd4,
    OP_RCR = 3'd5,
    OP_RCL = 3'd6,
    OP_NOP = 3'd7
  } shrot_op_e;

  localparam int FLAG_W = 8;
  localparam int CF_B   = 0;
  localparam int PF_B   = 1;
  localparam int ZF_B   = 2;
  localparam int SF_B   = 3;
  localparam int OF_B   = 4;
  localparam int XCF_B  = 5;

endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W      = 8,
  parameter int CNTM_W = 6
) (
  input  shrot_op_e         op,
  input  logic [CNTM_W-1:0] cnt,
  input  logic [W-1:0]      src,
  input  logic              cf_in,
  output logic [W-1:0]      res,
  output logic              carry,
  output logic              ovf
);

  logic [CNTM_W-1:0] cnt_m1;
  int unsigned       k_ro;
  int unsigned       k_rc;
  logic [W:0]        ext;
  logic [W:0]        rc;
  logic [W-1:0]      tap;

  assign cnt_m1 = cnt - CNTM_W'(1);
  assign k_ro   = 32'(cnt) % 32'(W);
  assign k_rc   = 32'(cnt) % 32'(W + 1);
  assign ext    = {cf_in, src};

  always_comb begin
    res   = src;
    carry = 1'b0;
    ovf   = 1'b0;
    tap   = '0;
    rc    = ext;
    case (op)
      OP_SHL: begin
        res   = src << cnt;
        tap   = src << cnt_m1;
        carry = tap[W-1];
        ovf   = tap[W-1] ^ res[W-1];
      end
      OP_SHR: begin
        res   = src >> cnt;
        tap   = src >> cnt_m1;
        carry = tap[0];
        ovf   = src[W-1];
      end
      OP_SAR: begin
        res   = $signed(src) >>> cnt;
        tap   = $signed(src) >>> cnt_m1;
        carry = tap[0];
        ovf   = 1'b0;
      end
      OP_ROR: begin
        res   = (src >> k_ro) | (src << (32'(W) - k_ro));
        carry = res[W-1];
        ovf   = res[W-1] ^ res[W-2];
      end
      OP_ROL: begin
        res   = (src << k_ro) | (src >> (32'(W) - k_ro));
        carry = res[0];
        ovf   = res[W-1] ^ res[0];
      end
      OP_RCR: begin
        rc    = (ext >> k_rc) | (ext << (32'(W + 1) - k_rc));
        res   = rc[W-1:0];
        carry = rc[W];
        ovf   = cf_in ^ src[W-1];
      end
      OP_RCL: begin
        rc    = (ext << k_rc) | (ext >> (32'(W + 1) - k_rc));
        res   = rc[W-1:0];
        carry = rc[W];
        ovf   = rc[W-1] ^ rc[W];
      end
      default: begin
        res   = src;
        carry = 1'b0;
        ovf   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [FLAG_W-1:0] sel,
  input  logic              update,
  input  logic              carry,
  input  logic              ovf,
  input  logic              zero,
  input  logic              sign,
  input  logic              par_even,
  output logic [FLAG_W-1:0] flags_out
);

  always_comb begin
    flags_out = flags_in;
    if (update) begin
      if (sel[CF_B])  flags_out[CF_B]  = carry;
      if (sel[XCF_B]) flags_out[XCF_B] = carry;
      if (sel[OF_B])  flags_out[OF_B]  = ovf;
      if (sel[ZF_B])  flags_out[ZF_B]  = zero;
      if (sel[SF_B])  flags_out[SF_B]  = sign;
      if (sel[PF_B])  flags_out[PF_B]  = par_even;
    end
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int NUM_SIZES = 4,
  parameter int CNT_W     = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [2:0]                      in_op,
  input  logic [$clog2(NUM_SIZES)-1:0]    in_size,
  input  logic [(8<<(NUM_SIZES-1))-1:0]   in_src,
  input  logic [(8<<(NUM_SIZES-1))-1:0]   in_dst,
  input  logic [CNT_W-1:0]                in_cnt,
  input  logic [7:0]                      in_flags,
  input  logic [7:0]                      in_sel,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [(8<<(NUM_SIZES-1))-1:0]   out_dst,
  output logic [7:0]                      out_flags
);

  localparam int MAX_W  = 8 << (NUM_SIZES - 1);
  localparam int CNTM_W = $clog2(MAX_W);
  localparam int SZ_W   = $clog2(NUM_SIZES);

  shrot_op_e op_e;
  assign op_e = shrot_op_e'(in_op);

  logic [MAX_W-1:0]     lane_res  [NUM_SIZES];
  logic [MAX_W-1:0]     lane_mask [NUM_SIZES];
  logic [NUM_SIZES-1:0] lane_cf;
  logic [NUM_SIZES-1:0] lane_of;
  logic [NUM_SIZES-1:0] lane_zero;
  logic [NUM_SIZES-1:0] lane_msb;
  logic [NUM_SIZES-1:0] lane_cz;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [CNTM_W-1:0] cnt_g;
    logic [LW-1:0]     r;
    if (g == NUM_SIZES - 1) begin : g_full
      assign cnt_g = in_cnt[CNTM_W-1:0];
    end else begin : g_part
      assign cnt_g = {1'b0, in_cnt[CNTM_W-2:0]};
    end
    shrot_lane #(.W(LW), .CNTM_W(CNTM_W)) u_lane (
      .op    (op_e),
      .cnt   (cnt_g),
      .src   (in_src[LW-1:0]),
      .cf_in (in_flags[CF_B]),
      .res   (r),
      .carry (lane_cf[g]),
      .ovf   (lane_of[g])
    );
    assign lane_res[g]  = MAX_W'(r);
    assign lane_mask[g] = MAX_W'({LW{1'b1}});
    assign lane_zero[g] = (r == '0);
    assign lane_msb[g]  = r[LW-1];
    assign lane_cz[g]   = (cnt_g == '0);
  end

  logic [MAX_W-1:0] sel_res;
  logic             cnt_zero;
  logic             is_rot;
  logic             keep_dst;
  logic             upd;
  logic [MAX_W-1:0] merged;
  logic [7:0]       new_flags;

  assign sel_res  = lane_res[in_size];
  assign cnt_zero = lane_cz[in_size];
  assign is_rot   = (op_e == OP_ROR) || (op_e == OP_ROL) ||
                    (op_e == OP_RCR) || (op_e == OP_RCL);
  assign keep_dst = (op_e == OP_NOP) || (is_rot && cnt_zero);
  assign upd      = !cnt_zero && (op_e != OP_NOP);

  always_comb begin
    if (keep_dst) begin
      merged = in_dst;
    end else if (32'(in_size) < 32'(NUM_SIZES - 2)) begin
      merged = (in_dst & ~lane_mask[in_size]) | sel_res;
    end else begin
      merged = sel_res;
    end
  end

  shrot_flags u_flags (
    .flags_in  (in_flags),
    .sel       (in_sel),
    .update    (upd),
    .carry     (lane_cf[in_size]),
    .ovf       (lane_of[in_size]),
    .zero      (lane_zero[in_size]),
    .sign      (lane_msb[in_size]),
    .par_even  (~^sel_res[7:0]),
    .flags_out (new_flags)
  );

  logic unused_cnt_hi;
  assign unused_cnt_hi = ^in_cnt[CNT_W-1:CNTM_W] ^ (SZ_W == 0);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dst   <= '0;
      out_flags <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_dst   <= merged;
      out_flags <= new_flags;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
  import shrot_pkg::*;
#(
  parameter int NUM_SIZES = 4,
  parameter int CNT_W     = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            in_valid,
  input logic                            in_ready,
  input logic [2:0]                      in_op,
  input logic [$clog2(NUM_SIZES)-1:0]    in_size,
  input logic [(8<<(NUM_SIZES-1))-1:0]   in_src,
  input logic [(8<<(NUM_SIZES-1))-1:0]   in_dst,
  input logic [CNT_W-1:0]                in_cnt,
  input logic [7:0]                      in_flags,
  input logic [7:0]                      in_sel,
  input logic                            out_valid,
  input logic                            out_ready,
  input logic [(8<<(NUM_SIZES-1))-1:0]   out_dst,
  input logic [7:0]                      out_flags
);

  localparam int MAX_W  = 8 << (NUM_SIZES - 1);
  localparam int CNTM_W = $clog2(MAX_W);
  localparam int SZ_W   = $clog2(NUM_SIZES);

  logic acc;
  logic cz;
  logic unused_chk;
  assign acc = in_valid && in_ready;
  assign cz  = (in_size == SZ_W'(NUM_SIZES - 1)) ? (in_cnt[CNTM_W-1:0] == '0)
                                                 : (in_cnt[CNTM_W-2:0] == '0);
  assign unused_chk = ^in_src;

  // R1
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R1
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R1
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_flags));

  // R3
  zcnt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cz |=> out_flags == $past(in_flags));

  // R3
  zcnt_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cz && (in_op >= 3'd3) && (in_op <= 3'd6) |=> out_dst == $past(in_dst));

  // R4
  unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((out_flags ^ $past(in_flags)) & ~$past(in_sel) & 8'h3F) == 8'h00);

  // R7
  sar_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 3'd2) && in_sel[OF_B] && !cz |=> !out_flags[OF_B]);

  // R12
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_size == '0) |=> out_dst[MAX_W-1:8] == $past(in_dst[MAX_W-1:8]));

  // R13
  nop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 3'd7) |=> (out_dst == $past(in_dst)) && (out_flags == $past(in_flags)));

endmodule

bind shrot_unit shrot_unit_chk #(.NUM_SIZES(NUM_SIZES), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;

  typedef struct {
    logic [63:0] d;
    logic [7:0]  f;
    int          size;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [63:0] in_src = '0;
  logic [63:0] in_dst = '0;
  logic [7:0]  in_cnt = '0;
  logic [7:0]  in_flags = '0;
  logic [7:0]  in_sel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_dst;
  logic [7:0]  out_flags;

  int   nchk = 0;
  int   nerr = 0;
  int   nsent = 0;
  int   nrecv = 0;
  bit   bp = 1'b0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  shrot_unit u0 (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input int op, input int size, input logic [63:0] src,
                                input logic [63:0] dst, input logic [7:0] cnt,
                                input logic [7:0] fl, input logic [7:0] sel,
                                output logic [63:0] od, output logic [7:0] ofl);
    int w = 8 << size;
    int m = (size == 3) ? int'(cnt[5:0]) : int'(cnt[4:0]);
    logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] s = src & msk;
    logic [63:0] r = s;
    logic c = 1'b0;
    logic v = 1'b0;
    logic cc = fl[0];
    logic b;
    logic sgn = s[w-1];
    ofl = fl;
    if (op == 7 || (m == 0 && op >= 3)) begin
      od = dst;
      return;
    end
    if (m != 0) begin
      for (int i = 0; i < m; i++) begin
        case (op)
          0: begin c = r[w-1]; r = (r << 1) & msk; end
          1: begin c = r[0]; r = r >> 1; end
          2: begin c = r[0]; r = (r >> 1) | (64'(sgn) << (w - 1)); end
          3: begin b = r[0]; r = (r >> 1) | (64'(b) << (w - 1)); end
          4: begin b = r[w-1]; r = ((r << 1) & msk) | 64'(b); end
          5: begin b = r[0]; r = (r >> 1) | (64'(cc) << (w - 1)); cc = b; end
          default: begin b = r[w-1]; r = ((r << 1) & msk) | 64'(cc); cc = b; end
        endcase
      end
      case (op)
        0: v = c ^ r[w-1];
        1: v = s[w-1];
        2: v = 1'b0;
        3: begin c = r[w-1]; v = r[w-1] ^ r[w-2]; end
        4: begin c = r[0]; v = r[w-1] ^ r[0]; end
        5: begin c = cc; v = fl[0] ^ s[w-1]; end
        default: begin c = cc; v = r[w-1] ^ cc; end
      endcase
      if (sel[0]) ofl[0] = c;
      if (sel[5]) ofl[5] = c;
      if (sel[4]) ofl[4] = v;
      if (sel[2]) ofl[2] = (r == 64'd0);
      if (sel[3]) ofl[3] = r[w-1];
      if (sel[1]) ofl[1] = ~^r[7:0];
    end
    case (size)
      0: od = {dst[63:8], r[7:0]};
      1: od = {dst[63:16], r[15:0]};
      default: od = r;
    endcase
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3, 4: return "R8";
      5: return "R9";
      6: return "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic send(int op, int size, logic [63:0] src, logic [63:0] dst,
                      logic [7:0] cnt, logic [7:0] fl, logic [7:0] sel, string tag);
    exp_t e;
    model(op, size, src, dst, cnt, fl, sel, e.d, e.f);
    e.size = size;
    e.tag  = tag;
    @(negedge clk);
    in_op = 3'(op); in_size = 2'(size); in_src = src; in_dst = dst;
    in_cnt = cnt; in_flags = fl; in_sel = sel; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q.push_back(e);
    nsent++;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
  end

  logic        held = 1'b0;
  logic [63:0] held_d;
  logic [7:0]  held_f;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (held && out_valid) begin
        check("R1", {48'd0, held_f, 8'd0} | 64'(0), {48'd0, out_flags, 8'd0});
        check("R1", out_dst, held_d);
      end
      held   = out_valid && !out_ready;
      held_d = out_dst;
      held_f = out_flags;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check("R1", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          nrecv++;
          check(e.tag, out_dst, e.d);
          check(e.tag, 64'(out_flags & 8'h31), 64'(e.f & 8'h31));
          check("R11", 64'(out_flags & 8'h0E), 64'(e.f & 8'h0E));
          check("R4", 64'(out_flags & 8'hC0), 64'(e.f & 8'hC0));
          if (e.size < 2) check("R12", out_dst[63:32], e.d[63:32]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nrecv, nsent);
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #3;
    check("R1", 64'(out_valid), 64'd0);
    check("R1", 64'(in_ready), 64'd1);

    // R5..R10: every op, every size, counts around the width
    for (int op = 0; op < 7; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        int w = 8 << sz;
        int lim = (sz == 3) ? 63 : 31;
        int cl[5] = '{1, w - 1, (w <= lim) ? w : 2, (w + 1 <= lim) ? w + 1 : 5, 17};
        for (int k = 0; k < 5; k++) begin
          send(op, sz, 64'hC3A5_0F81_7E24_9B16, 64'hFFFF_EEEE_DDDD_CCCC,
               8'(cl[k]), 8'hC1, 8'h3F, op_tag(op));
          send(op, sz, 64'h8000_0080_8000_8081, 64'h0123_4567_89AB_CDEF,
               8'(cl[k]), 8'h00, 8'h3F, op_tag(op));
        end
      end
    end

    // R2: count bits above the mask are ignored
    send(0, 3, 64'h0000_0000_0000_00F1, 64'd0, 8'hC1, 8'h00, 8'h3F, "R2");
    send(1, 1, 64'h0000_0000_0000_F0F1, 64'd0, 8'hE3, 8'h00, 8'h3F, "R2");
    send(4, 0, 64'h0000_0000_0000_0081, 64'd0, 8'h61, 8'h00, 8'h3F, "R2");

    // R3: zero effective count
    send(0, 3, 64'h1234_5678_9ABC_DEF0, 64'hAAAA, 8'h40, 8'hD5, 8'h3F, "R3");
    send(3, 0, 64'h1234_5678_9ABC_DEF0, 64'hAAAA_BBBB, 8'h20, 8'h2A, 8'h3F, "R3");
    send(6, 2, 64'hFFFF_0000_FFFF_0000, 64'h5555_6666, 8'h00, 8'h3F, 8'h3F, "R3");
    send(2, 1, 64'hFFFF_0000_FFFF_8000, 64'h5555_6666_7777_8888, 8'h00, 8'h00, 8'h3F, "R3");

    // R4: partial and empty select masks
    send(0, 3, 64'h8000_0000_0000_0000, 64'd0, 8'd1, 8'hC0, 8'h01, "R4");
    send(4, 2, 64'h8000_0001, 64'd0, 8'd1, 8'hFF, 8'h00, "R4");
    send(5, 1, 64'h0001, 64'd0, 8'd1, 8'h20, 8'h10, "R4");

    // R12: destination merging per size
    for (int sz = 0; sz < 4; sz++)
      send(1, sz, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd4, 8'h00, 8'h3F, "R12");

    // R13: reserved op
    send(7, 3, 64'hDEAD, 64'hBEEF_0000_1111_2222, 8'd5, 8'h9C, 8'h3F, "R13");

    // Random traffic under back-pressure
    bp = 1'b1;
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom % 8);
      send(op, int'($urandom % 4), {$urandom, $urandom}, {$urandom, $urandom},
           8'($urandom), 8'($urandom), 8'($urandom), op_tag(op));
    end

    while (q.size() != 0) @(posedge clk);
    bp = 1'b0;
    repeat (3) @(posedge clk);
    check("R1", 64'(nrecv), 64'(nsent));
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule